// File: doc/BRIEF.md
# Reloadable Watchdog Timer

This block is a 32-bit down-counter that advances once for every cycle in which a peripheral tick enable is high. It runs on the fast clock. When the count expires, the block drives a timeout output high for a fixed run of sixteen fast-clock cycles. It then reloads the counter from a programmed reload value and keeps counting. The timeout output can feed a reset controller, an interrupt controller or a hang indicator. Those consumers are not part of this block.

A mode input selects one of three behaviours:

- **Watchdog mode:** the counter is serviced only by a guarded two-word key sequence.
- **Bus-monitor mode:** every pulse on a bus-activity input reloads the counter, so a timeout means the bus stayed idle for the programmed period.
- **General-timer mode:** any write to the key register reloads the counter.

The register write port is a plain strobe. A write is taken on every clock edge where `wr_en` is high, so there is no back-pressure. The port addresses two registers: the reload value (`wr_sel`=0) and the key/service register (`wr_sel`=1).

Top module: `wdog_timer`

## Requirements
- R1: The counter decreases by exactly one on each clock edge where `tick_en` is high and no reload occurs. It does not change on any other edge.
- R2: A tick at which the count is 1 (or 0) is an expiry. The counter loads the reload value, so a count of N expires on its N-th tick, and after an expiry the next one follows N ticks later using the reload value current at that time.
- R3: After an expiry edge, `timeout_o` is high in exactly the 16 clock cycles that follow that edge, then returns low.
- R4: An expiry while `timeout_o` is high restarts the 16-cycle count, stretching the pulse.
- R5: Reset (`rst_n` low) sets the reload value and the counter to all ones and drives `timeout_o` low.
- R6: A write with `wr_sel`=0 stores all 32 bits of `wr_data` as the reload value. The write does not change the running count.
- R7: In watchdog mode (`mode` 0 or 3), a key write of 0x0000AAAA arms the guard, and a following key write of 0x00005555 reloads the counter. Any other write to either register cancels the armed state, and 0x00005555 without arming has no effect.
- R8: In bus-monitor mode (`mode`=1), each clock edge with `bus_act` high reloads the counter, and key writes have no effect on the count.
- R9: In general-timer mode (`mode`=2), any write with `wr_sel`=1 reloads the counter regardless of data.
- R10: A reload and a tick on the same edge leave the counter at the reload value. That edge is not an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Peripheral tick; one count step per high cycle |
| mode | input | 2 | 0/3 watchdog, 1 bus monitor, 2 general timer |
| bus_act | input | 1 | Bus-activity pulse, used in bus-monitor mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 reload value, 1 key/service register |
| wr_data | input | 32 | Write data |
| timeout_o | output | 1 | Timeout pulse, 16 clock cycles long |

## Verification
The embedded assertions check several behaviours on every cycle:

- the one-step decrement and the hold when no tick arrives;
- that a reload lands exactly on the stored reload value;
- that a service from the key guard only follows an armed state and disarms it;
- that the timeout pulse starts right after an expiry and never falls before sixteen cycles.

Some behaviours can only be shown by the bench's directed scenarios, because they depend on sequences of writes and mode choices:

- the end-to-end period seen at the output;
- pulse stretching under back-to-back expiries;
- rejection of broken or unarmed key sequences;
- the idle-bus timeout in bus-monitor mode;
- that a reload-value write leaves the running count alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_WDOG     = 2'd0,
    MODE_BUSMON   = 2'd1,
    MODE_TIMER    = 2'd2,
    MODE_WDOG_ALT = 2'd3
  } wdt_mode_e;

  localparam int unsigned KEY_W = 32;
  localparam logic [KEY_W-1:0] KEY_ARM  = 32'h0000_AAAA;
  localparam logic [KEY_W-1:0] KEY_FIRE = 32'h0000_5555;

  localparam logic SEL_RELOAD = 1'b0;
  localparam logic SEL_KEY    = 1'b1;
endpackage

// File: rtl/wdt_key_guard.sv
module wdt_key_guard
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          svc_o
);
  logic armed_q;
  logic is_arm, is_fire;

  assign is_arm  = wr_en && (wr_sel == SEL_KEY) && (wr_data == DW'(KEY_ARM));
  assign is_fire = wr_en && (wr_sel == SEL_KEY) && (wr_data == DW'(KEY_FIRE));
  assign svc_o   = is_fire && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_en)  armed_q <= is_arm;
  end

  // R7: a service disarms the guard
  a_r7_disarm_after_svc: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |=> !armed_q);
  // R7: the guard is armed only by the arm key
  a_r7_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(wr_en) && ($past(wr_data) == DW'(KEY_ARM)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] reload_val,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = (cnt_q <= CW'(1));
  assign expire_o = tick && !load && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '1;
    else if (load || expire_o) cnt_q <= reload_val;
    else if (tick)             cnt_q <= cnt_q - CW'(1);
  end

  // R1: one step per tick
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_end) |=> cnt_q == $past(cnt_q) - CW'(1));
  // R1: hold without tick or reload
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  // R10: reload wins over a tick
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(reload_val));
  // R2: expiry loads the reload value
  a_r2_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_q == $past(reload_val));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= PW'(LEN);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign pulse_o = (left_q != '0);

  logic [PW:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       hi_run_q <= '0;
    else if (fire)    hi_run_q <= '0;
    else if (pulse_o) hi_run_q <= hi_run_q + (PW+1)'(1);
    else              hi_run_q <= '0;
  end

  // R3: pulse follows an expiry on the next cycle
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse_o);
  // R3: pulse rises only after an expiry
  a_r3_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire));
  // R3/R4: pulse never drops before its full length
  a_r3_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> hi_run_q == (PW+1)'(LEN));
  // R3: pulse never outlasts its length
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> hi_run_q < (PW+1)'(LEN));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CW        = 32,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [1:0]    mode,
  input  logic          bus_act,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic          timeout_o
);
  logic [CW-1:0] reload_q;
  logic          key_svc;
  logic          reload_evt;
  logic          expire;
  wdt_mode_e     mode_e;

  assign mode_e = wdt_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n)                                  reload_q <= '1;
    else if (wr_en && (wr_sel == SEL_RELOAD))    reload_q <= wr_data;
  end

  wdt_key_guard #(.DW(CW)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .svc_o   (key_svc)
  );

  always_comb begin
    unique case (mode_e)
      MODE_BUSMON: reload_evt = bus_act;
      MODE_TIMER:  reload_evt = wr_en && (wr_sel == SEL_KEY);
      default:     reload_evt = key_svc;
    endcase
  end

  wdt_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .load       (reload_evt),
    .reload_val (reload_q),
    .expire_o   (expire)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (expire),
    .pulse_o (timeout_o)
  );

  // R8: in bus-monitor mode key writes never reload
  a_r8_busmon_src: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_BUSMON) |-> (reload_evt == bus_act));
  // R6: reload register changes only on its own write
  a_r6_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_RELOAD) |=> $stable(reload_q));
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        bus_act = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        timeout_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .bus_act(bus_act), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // n ticks, no timeout expected meanwhile
  task automatic ticks(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (timeout_o) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  // ticks every cycle until timeout rises; returns at the first high sample
  task automatic to_timeout(input int exp, input string req);
    int n = 0;
    @(negedge clk);
    tick_en = 1'b1;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (timeout_o) break;
    end
    tick_en = 1'b0;
    chk(n == exp, req, n, exp);
  endtask

  task automatic pulse_width(input string req);
    int w = 1;
    while (w < 100) begin
      @(negedge clk);
      if (!timeout_o) break;
      w++;
    end
    chk(w == 16, req, w, 16);
  endtask

  task automatic t_reset;
    chk(timeout_o == 1'b0, "R5 timeout low after reset", timeout_o, 0);
    ticks(300, "R5 all-ones start gives no early timeout");
  endtask

  task automatic t_timer;
    mode = 2'd2;
    wr(1'b0, 32'd5);
    wr(1'b1, 32'd0);
    to_timeout(5, "R9 plain key write reloads, R2 period");
    pulse_width("R3 pulse length 16");
    ticks(2, "R1 partial count");
    wr(1'b0, 32'd12);
    to_timeout(3, "R6 reload write leaves count alone");
    pulse_width("R3 pulse length second");
    to_timeout(12, "R2 auto reload with new value");
    pulse_width("R3 pulse length third");
    ticks(2, "R1 partial count before collision");
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'd7; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    to_timeout(12, "R10 reload beats same-edge tick");
    pulse_width("R3 pulse after collision");
  endtask

  task automatic t_retrigger;
    int w;
    mode = 2'd2;
    wr(1'b0, 32'd10);
    wr(1'b1, 32'd0);
    to_timeout(10, "R2 first expiry");
    w = 1;
    tick_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (timeout_o) w++;
    end
    tick_en = 1'b0;
    while (w < 100) begin
      @(negedge clk);
      if (!timeout_o) break;
      w++;
    end
    chk(w == 26, "R4 expiry during pulse restarts 16 count", w, 26);
  endtask

  task automatic t_watchdog;
    mode = 2'd0;
    wr(1'b0, 32'd8);
    wr(1'b1, 32'h0000_AAAA);
    wr(1'b1, 32'h0000_5555);
    ticks(5, "R7 count after key load");
    wr(1'b1, 32'h0000_AAAA);
    wr(1'b1, 32'h0000_5555);
    to_timeout(8, "R7 valid key sequence reloads");
    pulse_width("R3 pulse in watchdog mode");
    ticks(5, "R7 partial count");
    wr(1'b1, 32'h0000_AAAA);
    wr(1'b1, 32'h0000_1234);
    wr(1'b1, 32'h0000_5555);
    to_timeout(3, "R7 broken sequence ignored");
    pulse_width("R3 pulse after broken sequence");
    ticks(5, "R7 partial count");
    wr(1'b1, 32'h0000_5555);
    to_timeout(3, "R7 unarmed fire key ignored");
    pulse_width("R3 pulse after unarmed key");
    ticks(5, "R7 partial count");
    wr(1'b1, 32'h0000_AAAA);
    wr(1'b0, 32'd8);
    wr(1'b1, 32'h0000_5555);
    to_timeout(3, "R7 reload-register write cancels arm");
    pulse_width("R3 pulse after cancel");
    mode = 2'd3;
    ticks(5, "R7 partial count alt mode");
    wr(1'b1, 32'h0000_AAAA);
    wr(1'b1, 32'h0000_5555);
    to_timeout(8, "R7 mode 3 acts as watchdog");
    pulse_width("R3 pulse alt mode");
  endtask

  task automatic t_busmon;
    int hits = 0;
    mode = 2'd1;
    wr(1'b0, 32'd6);
    @(negedge clk);
    bus_act = 1'b1;
    @(negedge clk);
    bus_act = 1'b0;
    for (int i = 0; i < 24; i++) begin
      tick_en = 1'b1;
      bus_act = (i % 4 == 3);
      @(negedge clk);
      if (timeout_o) hits++;
    end
    tick_en = 1'b0; bus_act = 1'b0;
    chk(hits == 0, "R8 bus activity keeps timer from expiring", hits, 0);
    ticks(2, "R8 partial count");
    wr(1'b1, 32'h0000_AAAA);
    wr(1'b1, 32'h0000_5555);
    wr(1'b1, 32'h0000_0000);
    to_timeout(4, "R8 key writes ignored, idle bus times out");
    pulse_width("R3 pulse in bus-monitor mode");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_timer;
    t_retrigger;
    t_watchdog;
    t_busmon;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule